// File: doc/BRIEF.md
# Atomic Fetch-and-Op Unit

This unit carries out one atomic read-modify-write to memory for each accepted instruction. It takes the raw 32-bit instruction word, the 64-bit address operand and the 64-bit data operand, and decodes the instruction itself. A recognized instruction becomes a read, then a write, on a simple request/acknowledge memory port. A lock output stays high across both accesses, so no other requester can reach the memory between them.

Two instruction families are handled. Load-and-op forms change a word or a doubleword in memory and return its previous contents, together with a destination register index, for writeback. The changes are increment, decrement, fill with ones, fill with zeros, add the operand, and exchange with the operand. Store-and-add forms add the operand to memory and return nothing. A request that is misaligned for its size raises an error pulse and touches no memory.

Top module: `amo_unit`

## Requirements
- R1: An instruction is accepted only when bits 31:26 are 011100 and it is one of two forms. A load-and-op has bits 5:0 = 011111, bit 7 = 1, bits 10:8 from 000 to 101, and bit 6 selecting the size (0 word, 1 doubleword). A store-and-add has bits 5:1 = 01100, bits 15:6 all zero, and bit 0 selecting the size. Any other word causes no memory access, no writeback and no error.
- R2: An accepted, aligned instruction makes exactly one read and then one write, both at `req_addr`. `mem_lock` is high from the read request until the write acknowledge.
- R3: Operation code 000 stores old+1 and code 001 stores old-1, both wrapping modulo the access size.
- R4: Operation code 010 stores all ones of the access size (0x00000000FFFFFFFF for a word). Operation code 011 stores zero.
- R5: Operation code 100 stores old plus `req_opnd`, modulo the access size. Operation code 101 stores `req_opnd` truncated to the access size.
- R6: For a load-and-op, `wb_valid` is high in the cycle the read acknowledge arrives, and only then. In that cycle `wb_data` holds the old value and `wb_idx` holds instruction bits 15:11.
- R7: For a word access, the memory returns the word in `mem_rdata[31:0]` and bits 63:32 are ignored. The old value is zero-extended, and the new word goes out on `mem_wdata[31:0]` with bits 63:32 zero.
- R8: A store-and-add adds `req_opnd` to memory at `req_addr` and never asserts `wb_valid`.
- R9: A word request with `req_addr[1:0]` nonzero, or a doubleword request with `req_addr[2:0]` nonzero, pulses `addr_err` for one cycle, in the cycle after acceptance, and makes no memory access.
- R10: `busy` is high from the cycle after acceptance until the write acknowledge. Requests presented while `busy` is high are ignored.
- R11: During and after reset, `busy`, `mem_req`, `mem_lock`, `wb_valid` and `addr_err` are low.
- R12: Once `mem_req` is raised, it and `mem_addr`, `mem_we` and `mem_wdata` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction offered this cycle |
| req_insn | input | 32 | Raw instruction word |
| req_addr | input | 64 | Address operand value |
| req_opnd | input | 64 | Data operand value |
| busy | output | 1 | Operation in progress; new requests ignored |
| addr_err | output | 1 | One-cycle misalignment error pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_lock | output | 1 | Memory held for this unit |
| mem_size | output | 1 | 1 = doubleword, 0 = word |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data, word right-justified |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| wb_valid | output | 1 | Old value available for writeback |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Old memory value |

## Verification
A wrong latched operation or size in this unit shows at the ports in the write phase, as a wrong `mem_wdata`. A wrong state shows sooner, one cycle after acceptance, as a missing or extra `mem_req` or `busy`. A lock or request that drops between the two phases is visible in the cycle after the read acknowledge. Every operation is followed to memory contents and writeback values, so a corrupted old value or index appears in the read-acknowledge cycle itself. Random acknowledge latencies test that the request stays stable while the unit waits.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam int IDX_W = 5;

    typedef enum logic [2:0] {
        AMO_INC = 3'd0,
        AMO_DEC = 3'd1,
        AMO_SET = 3'd2,
        AMO_CLR = 3'd3,
        AMO_ADD = 3'd4,
        AMO_SWP = 3'd5
    } amo_op_e;

    typedef struct packed {
        logic             valid;
        amo_op_e          op;
        logic             dword;
        logic             wb_en;
        logic [IDX_W-1:0] rd;
    } amo_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } amo_state_e;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [31:0] insn,
    output amo_cmd_t    cmd
);
    localparam logic [5:0] MAJOR   = 6'b011100;
    localparam logic [5:0] FN_LOP  = 6'b011111;
    localparam logic [4:0] FN_SADD = 5'b01100;
    localparam logic [2:0] OP_MAX  = 3'd5;

    logic unused_regs;
    assign unused_regs = ^insn[25:16];

    always_comb begin
        cmd       = '0;
        cmd.op    = AMO_ADD;
        if (insn[31:26] == MAJOR) begin
            if (insn[5:0] == FN_LOP && insn[7] && insn[10:8] <= OP_MAX) begin
                cmd.valid = 1'b1;
                cmd.op    = amo_op_e'(insn[10:8]);
                cmd.dword = insn[6];
                cmd.wb_en = 1'b1;
                cmd.rd    = insn[15:11];
            end else if (insn[5:1] == FN_SADD && insn[15:6] == 10'd0) begin
                cmd.valid = 1'b1;
                cmd.op    = AMO_ADD;
                cmd.dword = insn[0];
                cmd.wb_en = 1'b0;
                cmd.rd    = '0;
            end
        end
    end
endmodule

// File: rtl/amo_align.sv
module amo_align #(
    parameter int ADDR_W     = 64,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dword,
    output logic              misaligned
);
    localparam int WLSB = $clog2(WORD_BYTES);
    localparam int DLSB = WLSB + 1;

    logic unused_hi;
    assign unused_hi = ^addr[ADDR_W-1:DLSB];

    always_comb begin
        if (dword) misaligned = |addr[DLSB-1:0];
        else       misaligned = |addr[WLSB-1:0];
    end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_op_e           op,
    input  logic              dword,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] new_val
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] size_mask;
    logic [DATA_W-1:0] raw;

    always_comb begin
        size_mask = dword ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
        unique case (op)
            AMO_INC: raw = old_val + DATA_W'(1);
            AMO_DEC: raw = old_val - DATA_W'(1);
            AMO_SET: raw = {DATA_W{1'b1}};
            AMO_CLR: raw = '0;
            AMO_ADD: raw = old_val + operand;
            AMO_SWP: raw = operand;
            default: raw = old_val;
        endcase
        new_val = raw & size_mask;
    end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ADDR_W     = 64,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_insn,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_opnd,
    output logic              busy,
    output logic              addr_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic              mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data
);
    localparam int HALF = DATA_W / 2;
    localparam int WLSB = $clog2(WORD_BYTES);
    localparam int DLSB = WLSB + 1;

    typedef struct packed {
        amo_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] opnd;
        amo_cmd_t          cmd;
        logic [DATA_W-1:0] newv;
        logic              err;
    } ctl_t;

    ctl_t s_d, s_q;

    amo_cmd_t          dec_cmd;
    logic              dec_misaligned;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] alu_new;

    amo_decode u_decode (
        .insn (req_insn),
        .cmd  (dec_cmd)
    );

    amo_align #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_align (
        .addr       (req_addr),
        .dword      (dec_cmd.dword),
        .misaligned (dec_misaligned)
    );

    // word reads keep only the low half of the returned data
    assign old_val = s_q.cmd.dword ? mem_rdata : {{HALF{1'b0}}, mem_rdata[HALF-1:0]};

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (s_q.cmd.op),
        .dword   (s_q.cmd.dword),
        .old_val (old_val),
        .operand (s_q.opnd),
        .new_val (alu_new)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid && dec_cmd.valid) begin
                    if (dec_misaligned) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.st   = ST_READ;
                        s_d.addr = req_addr;
                        s_d.opnd = req_opnd;
                        s_d.cmd  = dec_cmd;
                    end
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    s_d.newv = alu_new;
                    s_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign addr_err  = s_q.err;
    assign mem_req   = (s_q.st == ST_READ) || (s_q.st == ST_WRITE);
    assign mem_we    = (s_q.st == ST_WRITE);
    assign mem_lock  = mem_req;
    assign mem_size  = s_q.cmd.dword;
    assign mem_addr  = s_q.addr;
    assign mem_wdata = s_q.newv;
    assign wb_valid  = (s_q.st == ST_READ) && mem_ack && s_q.cmd.wb_en;
    assign wb_idx    = s_q.cmd.rd;
    assign wb_data   = old_val;

    // R2
    lock_into_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_lock));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R6
    wb_on_read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (mem_req && mem_ack && !mem_we));

    // R9
    err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !mem_req);

    // R9
    aligned_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_size ? (mem_addr[DLSB-1:0] == '0) : (mem_addr[WLSB-1:0] == '0)));

    // R7
    word_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_size) |-> (mem_wdata[DATA_W-1:HALF] == '0));

    // R10
    read_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && dec_cmd.valid && !dec_misaligned) |=> (mem_req && !mem_we));
endmodule

// File: tb/tb_amo_unit.sv
`timescale 1ns/100ps
module tb_amo_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_insn;
    logic [63:0] req_addr, req_opnd;
    logic        busy, addr_err, mem_req, mem_we, mem_lock, mem_size;
    logic [63:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ack;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;

    always #2.5 clk = ~clk;

    amo_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_insn(req_insn),
        .req_addr(req_addr), .req_opnd(req_opnd), .busy(busy), .addr_err(addr_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    localparam logic [63:0] BASE = 64'h1000;

    int n_total = 0;
    int n_fail  = 0;
    logic [63:0] mem  [16];
    logic [63:0] snap [16];
    int n_rd, n_wr, wb_cnt;
    logic [63:0] rd_addr_seen, wb_d;
    logic [4:0]  wb_i;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lop(input logic [2:0] op, input bit dw, input logic [4:0] rd);
        return {6'b011100, 5'd3, 5'd9, rd, op, 1'b1, dw, 6'b011111};
    endfunction

    function automatic logic [31:0] sadd(input bit dw);
        return {6'b011100, 5'd4, 5'd6, 10'd0, 5'b01100, dw};
    endfunction

    function automatic logic [63:0] rd_mem(input logic [63:0] a, input bit dw);
        if (dw) return mem[a[6:3]];
        return a[2] ? {32'd0, mem[a[6:3]][63:32]} : {32'd0, mem[a[6:3]][31:0]};
    endfunction

    function automatic logic [63:0] exp_new(input logic [2:0] op, input bit dw,
                                             input logic [63:0] old, input logic [63:0] opnd);
        logic [63:0] r;
        case (op)
            3'd0: r = old + 64'd1;
            3'd1: r = old - 64'd1;
            3'd2: r = '1;
            3'd3: r = '0;
            3'd4: r = old + opnd;
            default: r = opnd;
        endcase
        return dw ? r : (r & 64'h0000_0000_FFFF_FFFF);
    endfunction

    // memory responder with random latency
    initial begin
        bit pend = 0;
        int lat = 0;
        logic [63:0] hold_addr = '0;
        logic hold_we = 1'b0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                chk(mem_lock, "R2", "lock during access", {63'd0, mem_lock}, 64'd1);
                if (!pend) begin
                    pend = 1; hold_addr = mem_addr; hold_we = mem_we; lat = $urandom % 3;
                end else begin
                    chk(mem_addr == hold_addr && mem_we == hold_we, "R12", "request stable",
                        mem_addr, hold_addr);
                end
                if (lat == 0) begin
                    if (!mem_we) begin
                        n_rd++;
                        rd_addr_seen = mem_addr;
                        mem_rdata = rd_mem(mem_addr, mem_size);
                        if (!mem_size) mem_rdata[63:32] = $urandom;
                    end else begin
                        n_wr++;
                        if (mem_size) mem[mem_addr[6:3]] = mem_wdata;
                        else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] = mem_wdata[31:0];
                        else mem[mem_addr[6:3]][31:0] = mem_wdata[31:0];
                    end
                    mem_ack = 1'b1;
                    pend = 0;
                end else lat--;
            end
            #1;
            if (wb_valid) begin wb_cnt++; wb_d = wb_data; wb_i = wb_idx; end
        end
    end

    task automatic run_op(input logic [31:0] insn, input logic [63:0] addr,
                          input logic [63:0] opnd, input string tag);
        bit is_lop, is_sad, dw, mis, act;
        logic [63:0] old, nv;
        bit err_seen, busy_seen;
        is_lop = insn[31:26] == 6'b011100 && insn[5:0] == 6'b011111 && insn[7] && insn[10:8] <= 3'd5;
        is_sad = insn[31:26] == 6'b011100 && insn[5:1] == 5'b01100 && insn[15:6] == 10'd0;
        dw  = is_lop ? insn[6] : insn[0];
        mis = dw ? (addr[2:0] != 0) : (addr[1:0] != 0);
        act = (is_lop || is_sad) && !mis;
        for (int i = 0; i < 16; i++) snap[i] = mem[i];
        old = rd_mem(addr, dw);
        nv  = exp_new(is_lop ? insn[10:8] : 3'd4, dw, old, opnd);
        if (act) begin
            if (dw) snap[addr[6:3]] = nv;
            else if (addr[2]) snap[addr[6:3]][63:32] = nv[31:0];
            else snap[addr[6:3]][31:0] = nv[31:0];
        end
        @(negedge clk);
        n_rd = 0; n_wr = 0; wb_cnt = 0;
        req_valid = 1'b1; req_insn = insn; req_addr = addr; req_opnd = opnd;
        @(negedge clk);
        req_valid = 1'b0;
        err_seen = addr_err; busy_seen = busy;
        chk(err_seen == ((is_lop || is_sad) && mis), "R9", "addr_err pulse",
            {63'd0, err_seen}, {63'd0, (is_lop || is_sad) && mis});
        chk(busy_seen == act, "R10", "busy after accept", {63'd0, busy_seen}, {63'd0, act});
        for (int k = 0; k < 60 && busy; k++) @(negedge clk);
        @(negedge clk); #2;
        chk(n_rd == int'(act) && n_wr == int'(act), tag, "access count",
            64'(n_rd * 16 + n_wr), 64'(act * 17));
        if (act) chk(rd_addr_seen == addr, "R2", "access address", rd_addr_seen, addr);
        chk(wb_cnt == int'(act && is_lop), is_sad ? "R8" : "R6", "writeback count",
            64'(wb_cnt), 64'(act && is_lop));
        if (act && is_lop) begin
            chk(wb_d == old, "R6", "old value", wb_d, old);
            chk(wb_i == insn[15:11], "R6", "dest index", {59'd0, wb_i}, {59'd0, insn[15:11]});
        end
        for (int i = 0; i < 16; i++)
            chk(mem[i] === snap[i], tag, $sformatf("memory[%0d]", i), mem[i], snap[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; req_insn = '0; req_addr = '0; req_opnd = '0;
        for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        // R11 during reset
        chk(!busy && !mem_req && !mem_lock && !wb_valid && !addr_err, "R11", "in reset",
            {59'd0, busy, mem_req, mem_lock, wb_valid, addr_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && !mem_lock && !wb_valid && !addr_err, "R11", "after reset",
            {59'd0, busy, mem_req, mem_lock, wb_valid, addr_err}, 64'd0);

        // R3 increment/decrement and wrap
        mem[0] = 64'd5;
        run_op(lop(3'd0, 1, 5'd7), BASE, 64'd0, "R3");
        mem[1] = 64'h1234_5678_FFFF_FFFF;
        run_op(lop(3'd0, 0, 5'd2), BASE + 8, 64'd0, "R3");
        mem[2] = 64'd0;
        run_op(lop(3'd1, 1, 5'd31), BASE + 16, 64'd0, "R3");
        run_op(lop(3'd1, 0, 5'd1), BASE + 28, 64'd0, "R3");
        // R4 fill forms
        run_op(lop(3'd2, 0, 5'd4), BASE + 32, 64'd0, "R4");
        run_op(lop(3'd2, 1, 5'd5), BASE + 40, 64'd0, "R4");
        run_op(lop(3'd3, 1, 5'd6), BASE + 48, 64'd0, "R4");
        run_op(lop(3'd3, 0, 5'd8), BASE + 60, 64'd0, "R4");
        // R5 add and exchange, R7 word truncation
        run_op(lop(3'd4, 1, 5'd9), BASE + 64, 64'hFFFF_0000_0000_0001, "R5");
        run_op(lop(3'd4, 0, 5'd10), BASE + 72, 64'hAAAA_BBBB_8000_0000, "R7");
        run_op(lop(3'd5, 1, 5'd11), BASE + 80, 64'hDEAD_BEEF_0123_4567, "R5");
        run_op(lop(3'd5, 0, 5'd12), BASE + 92, 64'hFFFF_FFFF_CAFE_F00D, "R7");
        // R8 store-and-add
        run_op(sadd(0), BASE + 100, 64'd77, "R8");
        run_op(sadd(1), BASE + 104, 64'h0000_0001_0000_0003, "R8");
        // R1 unrecognized encodings
        run_op(sadd(1) | 32'h0000_0040, BASE, 64'd1, "R1");
        run_op(lop(3'd6, 1, 5'd3), BASE, 64'd1, "R1");
        run_op(lop(3'd0, 1, 5'd3) & ~32'h0000_0080, BASE, 64'd1, "R1");
        run_op(lop(3'd0, 1, 5'd3) ^ 32'h0400_0000, BASE, 64'd1, "R1");
        // R9 misaligned
        run_op(lop(3'd0, 0, 5'd3), BASE + 2, 64'd0, "R9");
        run_op(lop(3'd2, 1, 5'd3), BASE + 4, 64'd0, "R9");
        run_op(sadd(1), BASE + 12, 64'd9, "R9");

        // R10 requests while busy are ignored
        begin
            logic [63:0] a_old, b_old;
            a_old = mem[2]; b_old = mem[3];
            @(negedge clk);
            n_rd = 0; n_wr = 0;
            req_valid = 1'b1; req_insn = lop(3'd4, 1, 5'd1); req_addr = BASE + 16; req_opnd = 64'd10;
            @(negedge clk);
            req_insn = lop(3'd2, 1, 5'd2); req_addr = BASE + 24;
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 60 && busy; k++) @(negedge clk);
            @(negedge clk); #2;
            chk(mem[3] === b_old, "R10", "ignored target", mem[3], b_old);
            chk(mem[2] === a_old + 64'd10, "R10", "first op", mem[2], a_old + 64'd10);
            chk(n_rd == 1 && n_wr == 1, "R10", "access count", 64'(n_rd * 16 + n_wr), 64'd17);
        end

        // random mix
        for (int t = 0; t < 300; t++) begin
            int sel;
            logic [63:0] a;
            logic [2:0] op;
            sel = $urandom % 20;
            a = BASE + 64'(($urandom % 16) * 8) + (($urandom % 2) ? 64'd4 : 64'd0);
            op = 3'($urandom % 6);
            if (sel < 15) run_op(lop(op, a[2] ? 1'b0 : 1'($urandom), 5'($urandom)), a,
                                 {$urandom, $urandom}, op < 2 ? "R3" : (op < 4 ? "R4" : "R5"));
            else if (sel < 18) run_op(sadd(a[2] ? 1'b0 : 1'($urandom)), a, {$urandom, $urandom}, "R8");
            else run_op(lop(op, 1'($urandom), 5'd1), a + 64'd1, 64'd0, "R9");
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule